// File: doc/BRIEF.md
# Serially Loaded Configuration Store with Lockable Readback

This block holds the configuration image of a small programmable logic array. A host loads, reads and clears the image through a four-wire serial port: serial clock, serial data in, serial data out and a mode line. The image has two regions. The functional region covers bit addresses 0 to 5827. A 64-bit user signature covers addresses 5828 to 5891, which gives 5892 addressable bits. The logic fabric reads the image in parallel, one 16-bit word per request, whatever the state of the lock. Bit i of word w is bit address 16*w + i.

The serial pins are brought into the system clock domain by synchronizers. The serial clock is therefore slow next to the system clock: each high phase and each low phase must last at least 6 system clocks. When mode is high, the host shifts in a 3-bit command. When mode is low, the host shifts in the operands or moves data for that command. A one-bit security cell, once set, makes every serial readback of the functional region return zeros. Signature readback is never affected. Only a bulk erase clears the security cell, and the erase runs for a fixed number of system clocks with a busy flag raised.

The board must pull serial data in low when it is not driven. An all-low command stream then decodes as the idle command, so a floating line can never start programming.

Top module: `cfg_serial_store`

## Requirements
- R1: After the synchronous reset, busy is 0 and serial data out is 0.
- R2: With mode high, three serial data bits are taken on rising serial-clock edges, most significant first, as a command: 000 idle, 001 erase all, 010 load address, 011 write data, 100 read data, 101 set security. The codes 110, 111 and 000 change no stored bit, start no erase and move no data.
- R3: After command 010, the next 13 rising edges with mode low shift in the bit address, most significant bit first. Further mode-low edges are ignored until a new command arrives.
- R4: After command 011, each mode-low rising edge stores serial data in at the current address and then adds one to the address. A write to an address of 5892 or above stores nothing.
- R5: After command 100, each falling serial-clock edge puts the bit at the current address on serial data out, and each mode-low rising edge adds one to the address. Addresses of 5892 or above read as 0. When the active command is anything other than read, a falling edge drives serial data out to 0.
- R6: While the security cell is set, serial readback of any address from 0 to 5827 returns 0.
- R7: Signature addresses 5828 to 5891 read back their stored values whether or not the security cell is set. Signature byte k occupies addresses 5828+8k to 5835+8k, with its least significant bit at the lowest address.
- R8: Command 001 raises busy on the next clock and holds it for exactly ERASE_CYCLES clocks. Busy then falls, every stored bit is 0 and the security cell is clear.
- R9: Commands and data edges that complete while busy is high have no effect.
- R10: The security cell falls only at the end of an erase. The synchronous reset does not clear it.
- R11: fab_data returns the stored word at fab_addr one clock after the address is presented, regardless of the security cell.
- R12: Serial data out changes only in the clock after a detected falling serial-clock edge. It is stable across a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; leaves stored bits and the security cell untouched |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in; the board pulls it low when undriven |
| smode | input | 1 | High: command shift; low: operand or data phase |
| sdo | output | 1 | Serial data out, updated after falling serial-clock edges |
| busy | output | 1 | High while a bulk erase runs |
| fab_addr | input | 9 | Fabric word address |
| fab_data | output | 16 | Fabric read data, one clock latency |

## Verification
The assertions check on every cycle that:
- an erase keeps busy high for exactly the configured length;
- every erase write carries zeros;
- no write targets a word beyond the array;
- the security cell falls only as busy ends;
- serial data out moves only after a falling-edge pulse.

Only the bench scenarios can show the protocol results:
- addresses load most significant bit first;
- written patterns come back through both serial readback and the fabric port;
- locked reads blank the functional region but not the signature, across the boundary at 5827/5828;
- writes above 5891 are dropped;
- commands sent during an erase leave no trace;
- a reset leaves the lock in place.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'b000,
    OP_ERASE  = 3'b001,
    OP_LDADDR = 3'b010,
    OP_WRDATA = 3'b011,
    OP_RDDATA = 3'b100,
    OP_LOCK   = 3'b101
  } op_e;

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic sdi,
  input  logic smode,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi_s,
  output logic mode_s
);

  logic [STAGES-1:0] sck_sh, sdi_sh, md_sh;
  logic              sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sh   <= '0;
      sdi_sh   <= '0;
      md_sh    <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_sh   <= {sck_sh[STAGES-2:0], sclk};
      sdi_sh   <= {sdi_sh[STAGES-2:0], sdi};
      md_sh    <= {md_sh[STAGES-2:0], smode};
      sck_prev <= sck_sh[STAGES-1];
    end
  end

  assign sclk_rise = sck_sh[STAGES-1] & ~sck_prev;
  assign sclk_fall = ~sck_sh[STAGES-1] & sck_prev;
  assign sdi_s     = sdi_sh[STAGES-1];
  assign mode_s    = md_sh[STAGES-1];

endmodule

// File: rtl/cfg_bit_ram.sv
module cfg_bit_ram #(
  parameter int DEPTH   = 369,
  parameter int WORD_W  = 16,
  parameter int WADDR_W = 9
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [WADDR_W-1:0] raddr_a,
  output logic [WORD_W-1:0]  rdata_a,
  input  logic [WADDR_W-1:0] raddr_b,
  output logic [WORD_W-1:0]  rdata_b
);

  logic [WORD_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/cfg_cmd_ctrl.sv
module cfg_cmd_ctrl
  import cfg_store_pkg::*;
#(
  parameter int MAIN_BITS    = 5828,
  parameter int TOTAL_BITS   = 5892,
  parameter int DEPTH        = 369,
  parameter int WORD_W       = 16,
  parameter int ADDR_W       = 13,
  parameter int WADDR_W      = 9,
  parameter int BSEL_W       = 4,
  parameter int ERASE_CYCLES = 512,
  parameter int ECNT_W       = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rise,
  input  logic               fall,
  input  logic               sdi_s,
  input  logic               mode_s,
  input  logic [WORD_W-1:0]  rd_word,
  output logic [WADDR_W-1:0] rd_idx,
  output logic               we,
  output logic [WADDR_W-1:0] waddr,
  output logic [WORD_W-1:0]  wdata,
  output logic               busy,
  output logic               lock,
  output logic               sdo
);

  localparam int ACNT_W = $clog2(ADDR_W + 1);

  op_e                op_q;
  logic [1:0]         opc_sh;
  logic [1:0]         opc_cnt;
  logic [ACNT_W-1:0]  abit_cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [ECNT_W-1:0]  ecnt_q;
  logic               busy_q;
  logic               lock_q = 1'b0;
  logic               sdo_q;
  logic               we_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [WORD_W-1:0]  wdata_q;

  logic [BSEL_W-1:0]  bsel;
  logic               in_range, hidden, vis_bit;
  logic               cmd_done, erase_last;
  op_e                new_code;
  logic [WORD_W-1:0]  merged;

  always_comb begin
    bsel       = addr_q[BSEL_W-1:0];
    rd_idx     = WADDR_W'(addr_q >> BSEL_W);
    in_range   = addr_q < ADDR_W'(TOTAL_BITS);
    hidden     = lock_q && (addr_q < ADDR_W'(MAIN_BITS));
    vis_bit    = in_range && !hidden && rd_word[bsel];
    cmd_done   = rise && mode_s && (opc_cnt == 2'd2);
    new_code   = op_e'({opc_sh, sdi_s});
    erase_last = busy_q && (ecnt_q == ECNT_W'(ERASE_CYCLES - 1));
    merged       = rd_word;
    merged[bsel] = sdi_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_IDLE;
      opc_sh   <= '0;
      opc_cnt  <= '0;
      abit_cnt <= '0;
      addr_q   <= '0;
      ecnt_q   <= '0;
      busy_q   <= 1'b0;
      sdo_q    <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (busy_q) begin
        we_q    <= ecnt_q < ECNT_W'(DEPTH);
        waddr_q <= WADDR_W'(ecnt_q);
        wdata_q <= '0;
        ecnt_q  <= ecnt_q + ECNT_W'(1);
        if (erase_last) busy_q <= 1'b0;
      end

      if (rise && mode_s) begin
        opc_sh <= {opc_sh[0], sdi_s};
        if (opc_cnt == 2'd2) begin
          opc_cnt <= '0;
          if (!busy_q) begin
            case (new_code)
              OP_ERASE: begin
                busy_q <= 1'b1;
                ecnt_q <= '0;
                op_q   <= OP_IDLE;
              end
              OP_LDADDR: begin
                op_q     <= OP_LDADDR;
                abit_cnt <= '0;
              end
              OP_WRDATA: op_q <= OP_WRDATA;
              OP_RDDATA: op_q <= OP_RDDATA;
              default:   op_q <= OP_IDLE;
            endcase
          end
        end else begin
          opc_cnt <= opc_cnt + 2'd1;
        end
      end else if (rise && !mode_s) begin
        opc_cnt <= '0;
        if (!busy_q) begin
          case (op_q)
            OP_LDADDR: begin
              addr_q   <= {addr_q[ADDR_W-2:0], sdi_s};
              abit_cnt <= abit_cnt + ACNT_W'(1);
              if (abit_cnt == ACNT_W'(ADDR_W - 1)) op_q <= OP_IDLE;
            end
            OP_WRDATA: begin
              if (in_range) begin
                we_q    <= 1'b1;
                waddr_q <= rd_idx;
                wdata_q <= merged;
              end
              addr_q <= addr_q + ADDR_W'(1);
            end
            OP_RDDATA: addr_q <= addr_q + ADDR_W'(1);
            default: ;
          endcase
        end
      end

      if (fall) sdo_q <= (op_q == OP_RDDATA) && !busy_q && vis_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (erase_last)
      lock_q <= 1'b0;
    else if (!rst && cmd_done && !busy_q && new_code == OP_LOCK)
      lock_q <= 1'b1;
  end

  assign we    = we_q;
  assign waddr = waddr_q;
  assign wdata = wdata_q;
  assign busy  = busy_q;
  assign lock  = lock_q;
  assign sdo   = sdo_q;

endmodule

// File: rtl/cfg_serial_store.sv
module cfg_serial_store #(
  parameter int MAIN_BITS    = 5828,
  parameter int SIG_BITS     = 64,
  parameter int WORD_W       = 16,
  parameter int ADDR_W       = 13,
  parameter int ERASE_CYCLES = 512,
  parameter int SYNC_STAGES  = 2,
  localparam int TOTAL_BITS  = MAIN_BITS + SIG_BITS,
  localparam int DEPTH       = (TOTAL_BITS + WORD_W - 1) / WORD_W,
  localparam int WADDR_W     = $clog2(DEPTH),
  localparam int BSEL_W      = $clog2(WORD_W),
  localparam int ECNT_W      = $clog2(ERASE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               smode,
  output logic               sdo,
  output logic               busy,
  input  logic [WADDR_W-1:0] fab_addr,
  output logic [WORD_W-1:0]  fab_data
);

  logic               sclk_rise, sclk_fall, sdi_s, mode_s;
  logic [WORD_W-1:0]  rd_word;
  logic [WADDR_W-1:0] rd_idx;
  logic               ram_we;
  logic [WADDR_W-1:0] ram_waddr;
  logic [WORD_W-1:0]  ram_wdata;
  logic               lock;

  cfg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .sdi       (sdi),
    .smode     (smode),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi_s     (sdi_s),
    .mode_s    (mode_s)
  );

  cfg_cmd_ctrl #(
    .MAIN_BITS    (MAIN_BITS),
    .TOTAL_BITS   (TOTAL_BITS),
    .DEPTH        (DEPTH),
    .WORD_W       (WORD_W),
    .ADDR_W       (ADDR_W),
    .WADDR_W      (WADDR_W),
    .BSEL_W       (BSEL_W),
    .ERASE_CYCLES (ERASE_CYCLES),
    .ECNT_W       (ECNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rise    (sclk_rise),
    .fall    (sclk_fall),
    .sdi_s   (sdi_s),
    .mode_s  (mode_s),
    .rd_word (rd_word),
    .rd_idx  (rd_idx),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .busy    (busy),
    .lock    (lock),
    .sdo     (sdo)
  );

  cfg_bit_ram #(
    .DEPTH   (DEPTH),
    .WORD_W  (WORD_W),
    .WADDR_W (WADDR_W)
  ) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .raddr_a (rd_idx),
    .rdata_a (rd_word),
    .raddr_b (fab_addr),
    .rdata_b (fab_data)
  );

endmodule

// File: rtl/cfg_serial_store_chk.sv
module cfg_serial_store_chk #(
  parameter int DEPTH        = 369,
  parameter int WORD_W       = 16,
  parameter int WADDR_W      = 9,
  parameter int ERASE_CYCLES = 512
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               lock,
  input logic               sdo,
  input logic               sclk_fall,
  input logic               ram_we,
  input logic [WADDR_W-1:0] ram_waddr,
  input logic [WORD_W-1:0]  ram_wdata
);

  int unsigned blen;

  always_ff @(posedge clk) begin
    if (rst)       blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  // R8
  erase_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> (blen == ERASE_CYCLES));

  // R8
  erase_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && ram_we) |-> (ram_wdata == '0));

  // R4
  write_range_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_waddr < WADDR_W'(DEPTH)));

  // R10
  lock_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) |-> $past(busy));

  // R12
  sdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(sdo)) |-> $past(sclk_fall));

endmodule

bind cfg_serial_store cfg_serial_store_chk #(
  .DEPTH        (DEPTH),
  .WORD_W       (WORD_W),
  .WADDR_W      (WADDR_W),
  .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .lock      (lock),
  .sdo       (sdo),
  .sclk_fall (sclk_fall),
  .ram_we    (ram_we),
  .ram_waddr (ram_waddr),
  .ram_wdata (ram_wdata)
);

// File: tb/sim_cfg_serial_store.sv
module sim_cfg_serial_store;

  localparam int ERASE_N = 400;
  localparam int HALF    = 8;
  localparam int SIG0    = 5828;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        smode = 1'b0;
  logic [8:0]  fab_addr = '0;
  logic        sdo, busy;
  logic [15:0] fab_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_serial_store #(.ERASE_CYCLES(ERASE_N)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .smode(smode),
    .sdo(sdo), .busy(busy), .fab_addr(fab_addr), .fab_data(fab_data)
  );

  function automatic int pat(int a);
    return (a & 1) ^ ((a >> 2) & 1) ^ ((a >> 4) & 1);
  endfunction

  function automatic int sigbit(int a);
    int off;
    if (a < SIG0 || a >= SIG0 + 64) return 0;
    off = a - SIG0;
    return ((8'hA0 + (off >> 3)) >> (off & 7)) & 1;
  endfunction

  function automatic int expv(int kind, int a);
    case (kind)
      1:       return pat(a);
      2:       return sigbit(a);
      3:       return (a < SIG0) ? 0 : sigbit(a);
      4:       return (a == 5890 || a == 5891) ? 1 : 0;
      5:       return (a == 100 || a == 102) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(bit m, bit d);
    smode = m; sdi = d;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_op(logic [2:0] c);
    tick(1'b1, c[2]); tick(1'b1, c[1]); tick(1'b1, c[0]);
  endtask

  task automatic load_addr(int a);
    send_op(3'b010);
    for (int i = 12; i >= 0; i--) tick(1'b0, a[i]);
  endtask

  task automatic check_read(int start, int n, int kind, string req);
    int got;
    load_addr(start);
    send_op(3'b100);
    for (int i = 0; i < n; i++) begin
      smode = 1'b0; sdi = 1'b0;
      repeat (HALF) @(negedge clk);
      got = int'(sdo);
      chk(got == expv(kind, start + i), req, got, expv(kind, start + i));
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      chk(int'(sdo) == got, "R12 sdo stable over rise", int'(sdo), got);
      sclk = 1'b0;
    end
  endtask

  task automatic check_fab(int w, int kind, string req);
    int e;
    fab_addr = 9'(w);
    repeat (2) @(negedge clk);
    e = 0;
    for (int i = 0; i < 16; i++) e |= expv(kind, w * 16 + i) << i;
    chk(int'(fab_data) == e, req, int'(fab_data), e);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(sdo == 1'b0, "R1 sdo after reset", int'(sdo), 0);
  endtask

  task automatic t_erase();
    int cnt = 0;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    smode = 1'b1; sdi = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    for (int i = 0; i < ERASE_N + 100; i++) begin
      @(negedge clk);
      if (i == HALF) sclk = 1'b0;
      if (busy) cnt++;
    end
    chk(cnt == ERASE_N, "R8 busy length", cnt, ERASE_N);
    check_read(0, 16, 0, "R8 erased bits read 0");
    check_fab(0, 0, "R8 first word erased");
    check_fab(368, 0, "R8 last word erased");
  endtask

  task automatic t_write_read();
    load_addr(100);
    send_op(3'b011);
    for (int i = 0; i < 40; i++) tick(1'b0, pat(100 + i) != 0);
    check_read(100, 40, 1, "R4 R5 pattern readback");
    check_fab(7, 1, "R11 fabric word");
  endtask

  task automatic t_addr_extra();
    send_op(3'b010);
    for (int i = 12; i >= 0; i--) tick(1'b0, (120 >> i) & 1);
    tick(1'b0, 1'b1); tick(1'b0, 1'b1);
    send_op(3'b100);
    for (int i = 0; i < 8; i++) begin
      repeat (HALF) @(negedge clk);
      chk(int'(sdo) == pat(120 + i), "R3 address MSB first, extra bits ignored",
          int'(sdo), pat(120 + i));
      tick(1'b0, 1'b0);
    end
  endtask

  task automatic t_idle_stream();
    send_op(3'b000); send_op(3'b000);
    send_op(3'b110); send_op(3'b111);
    repeat (HALF) @(negedge clk);
    chk(busy == 1'b0, "R2 no erase from idle codes", int'(busy), 0);
    chk(sdo == 1'b0, "R5 sdo low outside read", int'(sdo), 0);
    tick(1'b0, 1'b1); tick(1'b0, 1'b1);
    check_read(100, 8, 1, "R2 contents kept after idle codes");
  endtask

  task automatic t_range();
    load_addr(5890);
    send_op(3'b011);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
    check_read(5889, 5, 4, "R4 R5 writes above 5891 dropped");
  endtask

  task automatic t_lock();
    load_addr(SIG0);
    send_op(3'b011);
    for (int i = 0; i < 64; i++) tick(1'b0, sigbit(SIG0 + i) != 0);
    send_op(3'b101);
    check_read(100, 16, 0, "R6 locked functional read");
    check_read(5826, 66, 3, "R6 R7 boundary and signature while locked");
    check_fab(7, 1, "R11 fabric ignores lock");
  endtask

  task automatic t_lock_reset();
    send_op(3'b000);
    repeat (HALF) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R1 busy after second reset", int'(busy), 0);
    check_read(100, 8, 0, "R10 lock survives reset");
  endtask

  task automatic t_busy_ignore();
    int guard = 0;
    load_addr(0);
    send_op(3'b001);
    chk(busy == 1'b1, "R8 busy raised", int'(busy), 1);
    send_op(3'b011);
    send_op(3'b101);
    while (busy && guard < ERASE_N + 50) begin
      @(negedge clk);
      guard++;
    end
    chk(busy == 1'b0, "R8 busy falls", int'(busy), 0);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    check_read(0, 3, 0, "R9 write command during busy ignored");
    load_addr(100);
    send_op(3'b011);
    tick(1'b0, 1'b1); tick(1'b0, 1'b0); tick(1'b0, 1'b1);
    check_read(100, 3, 5, "R8 erase clears lock");
    check_fab(7, 0, "R8 pattern word erased");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_erase();
    t_write_read();
    t_addr_extra();
    t_idle_stream();
    t_range();
    t_lock();
    t_lock_reset();
    t_busy_ignore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule